// File: doc/BRIEF.md
# Fractional-N PLL Factor Calculator

This block turns two frequencies, a reference clock and a wanted system clock (both unsigned integers in hertz), into the settings that a fractional-N PLL needs. The settings are an integer multiplier, a 22-bit fraction, a post-divide-by-two flag, a reference-divide-by-two flag and a fraction-enable flag. The same results are also packed into three 9-bit control words, ready to be written into the PLL's configuration registers.

A job begins with a one-cycle `start` pulse. The block first derives the oscillator target and the effective reference. It then runs a single shared restoring divider three times: once for the integer multiplier, once for the scaled fraction and once for the decimal rounding step. Invalid requests finish at once and raise `range_err_o`. After a job ends, every result holds until the next accepted start.

Top module: `pll_factor_calc`

## Requirements
- R1: The oscillator target is four times `out_hz_i`. If that value is below 90,000,000, the target is doubled and `post_div2_o` is 1. Otherwise `post_div2_o` is 0. Both flags are updated on the clock edge that accepts `start_i`.
- R2: If the target is below 90,000,000 or above 100,000,000 (both limits are legal), the job fails. `range_err_o` and `done_o` become 1 one cycle after the start. `busy_o` never rises, and `n_int_o`, `k_frac_o` and `frac_en_o` are 0.
- R3: If `ref_hz_i` is above 15,000,000, the effective reference is `ref_hz_i` divided by two (rounded down) and `ref_div2_o` is 1. Otherwise the effective reference is `ref_hz_i` and `ref_div2_o` is 0.
- R4: `n_int_o` is the integer quotient of the target divided by the effective reference.
- R5: Let q be (remainder of that division × 41,943,040) divided by the effective reference, rounded down. If q mod 10 is 5 or more, 5 is added to q. `k_frac_o` is the low 22 bits of q/10.
- R6: `frac_en_o` is 1 exactly when `k_frac_o` is nonzero.
- R7: `ctl_hi_o` holds `n_int_o[4:0]` in bits 8:4 and `k_frac_o[21:18]` in bits 3:0. `ctl_mid_o` is `k_frac_o[17:9]`. `ctl_lo_o` is `k_frac_o[8:0]`.
- R8: A `ref_hz_i` of zero ends the job one cycle after the start with `range_err_o` = 1.
- R9: For a valid job, `busy_o` is high for exactly 198 cycles, which is 3 × (64 + 2). `done_o` rises in the cycle in which `busy_o` falls. `busy_o` and `done_o` are never both high. An accepted start clears `done_o` and `range_err_o` for a valid job.
- R10: A `start_i` pulse while `busy_o` is high is ignored. The running job finishes with the results of its own inputs.
- R11: After `done_o`, all outputs keep their values until the next accepted start, whatever the frequency inputs do in the meantime.
- R12: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a job (accepted only when not busy) |
| ref_hz_i | input | 32 | Reference frequency in Hz |
| out_hz_i | input | 32 | Desired system clock in Hz |
| busy_o | output | 1 | Divider passes in progress |
| done_o | output | 1 | Results valid, held until next start |
| range_err_o | output | 1 | Target out of window or zero reference |
| ref_div2_o | output | 1 | Reference was halved |
| post_div2_o | output | 1 | Target was doubled; PLL output divides by two |
| frac_en_o | output | 1 | Fraction is nonzero |
| n_int_o | output | 32 | Integer multiplier |
| k_frac_o | output | 22 | Fractional part |
| ctl_hi_o | output | 9 | Packed word: N low bits and K top bits |
| ctl_mid_o | output | 9 | Packed word: K middle bits |
| ctl_lo_o | output | 9 | Packed word: K low bits |

## Verification
The divider assertions assume that the controller never loads a zero divisor and never reloads the divider while it is still running. The hold assertions assume that `start_i` is a single-cycle pulse. The bench drives the inputs at the falling edge and raises `start_i` for only one cycle at a time. It deliberately pulses start during a running job, and it sends a zero reference, which the assertions must tolerate because the controller filters it before the divider. Inputs change freely while a job runs and after it ends, because the block samples them only on an accepted start.

// File: rtl/pll_calc_pkg.sv
package pll_calc_pkg;
  localparam int unsigned VCO_MIN_HZ      = 90_000_000;
  localparam int unsigned VCO_MAX_HZ      = 100_000_000;
  localparam int unsigned REF_HALVE_ABOVE = 15_000_000;
  localparam int unsigned FRAC_DECIMAL    = 10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LD_N,
    ST_RUN_N,
    ST_LD_K,
    ST_RUN_K,
    ST_LD_R,
    ST_RUN_R
  } calc_state_e;
endpackage

// File: rtl/pll_calc_prep.sv
module pll_calc_prep
  import pll_calc_pkg::*;
#(
  parameter int FREQ_W = 32,
  parameter int TGT_W  = FREQ_W + 3
) (
  input  logic [FREQ_W-1:0] ref_hz_i,
  input  logic [FREQ_W-1:0] out_hz_i,
  output logic [FREQ_W-1:0] ref_eff_o,
  output logic [TGT_W-1:0]  target_o,
  output logic              ref_div2_o,
  output logic              post_div2_o,
  output logic              bad_o
);
  logic [TGT_W-1:0] times4;

  always_comb begin
    ref_div2_o  = ref_hz_i > FREQ_W'(REF_HALVE_ABOVE);
    ref_eff_o   = ref_div2_o ? (ref_hz_i >> 1) : ref_hz_i;
    times4      = TGT_W'({out_hz_i, 2'b00});
    post_div2_o = times4 < TGT_W'(VCO_MIN_HZ);
    target_o    = post_div2_o ? (times4 << 1) : times4;
    bad_o       = (ref_hz_i == '0)
               || (target_o < TGT_W'(VCO_MIN_HZ))
               || (target_o > TGT_W'(VCO_MAX_HZ));
  end
endmodule

// File: rtl/pll_calc_div.sv
module pll_calc_div #(
  parameter int DVD_W = 64,
  parameter int DVS_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DVD_W-1:0] dividend_i,
  input  logic [DVS_W-1:0] divisor_i,
  output logic             busy_o,
  output logic [DVD_W-1:0] quot_o,
  output logic [DVS_W-1:0] rem_o
);
  localparam int CNT_W = $clog2(DVD_W + 1);

  logic [DVD_W-1:0] quot_q, quot_d;
  logic [DVS_W-1:0] rem_q, rem_d;
  logic [DVS_W-1:0] dvs_q, dvs_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DVS_W:0]   rem_sh;
  logic [DVS_W-1:0] diff;
  logic             fits;
  logic             step_en;

  always_comb begin
    rem_sh  = {rem_q, quot_q[DVD_W-1]};
    fits    = rem_sh >= {1'b0, dvs_q};
    diff    = rem_sh[DVS_W-1:0] - dvs_q;
    step_en = cnt_q != '0;
    quot_d  = quot_q;
    rem_d   = rem_q;
    dvs_d   = dvs_q;
    cnt_d   = cnt_q;
    if (load_i) begin
      quot_d = dividend_i;
      rem_d  = '0;
      dvs_d  = divisor_i;
      cnt_d  = CNT_W'(DVD_W);
    end else if (step_en) begin
      rem_d  = fits ? diff : rem_sh[DVS_W-1:0];
      quot_d = {quot_q[DVD_W-2:0], fits};
      cnt_d  = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quot_q <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
    end else begin
      quot_q <= quot_d;
      rem_q  <= rem_d;
      dvs_q  <= dvs_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy_o = step_en;
  assign quot_o = quot_q;
  assign rem_o  = rem_q;

  assert_rem_below_divisor_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_en |-> (rem_q < dvs_q));
  assert_nonzero_divisor_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (divisor_i != '0));
  assert_no_reload_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !step_en);
endmodule

// File: rtl/pll_calc_pack.sv
module pll_calc_pack #(
  parameter int K_W    = 22,
  parameter int WORD_W = 9,
  parameter int N_BITS = WORD_W - (K_W - 2 * WORD_W)
) (
  input  logic [N_BITS-1:0] n_low_i,
  input  logic [K_W-1:0]    k_i,
  output logic [WORD_W-1:0] word_hi_o,
  output logic [WORD_W-1:0] word_mid_o,
  output logic [WORD_W-1:0] word_lo_o
);
  localparam int LOW_WORDS = 2;
  localparam int K_TOP     = K_W - LOW_WORDS * WORD_W;

  logic [LOW_WORDS-1:0][WORD_W-1:0] slice;

  for (genvar g = 0; g < LOW_WORDS; g++) begin : g_slice
    assign slice[g] = k_i[g*WORD_W +: WORD_W];
  end

  assign word_lo_o  = slice[0];
  assign word_mid_o = slice[1];
  assign word_hi_o  = {n_low_i, k_i[K_W-1 -: K_TOP]};
endmodule

// File: rtl/pll_factor_calc.sv
module pll_factor_calc
  import pll_calc_pkg::*;
#(
  parameter int FREQ_W = 32,
  parameter int K_W    = 22,
  parameter int WORD_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [FREQ_W-1:0] ref_hz_i,
  input  logic [FREQ_W-1:0] out_hz_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              range_err_o,
  output logic              ref_div2_o,
  output logic              post_div2_o,
  output logic              frac_en_o,
  output logic [FREQ_W-1:0] n_int_o,
  output logic [K_W-1:0]    k_frac_o,
  output logic [WORD_W-1:0] ctl_hi_o,
  output logic [WORD_W-1:0] ctl_mid_o,
  output logic [WORD_W-1:0] ctl_lo_o
);
  localparam int DVD_W  = 2 * FREQ_W;
  localparam int DVS_W  = FREQ_W;
  localparam int TGT_W  = FREQ_W + 3;
  localparam int N_BITS = WORD_W - (K_W - 2 * WORD_W);

  // reset: asserted at once, released through two flops
  logic [1:0] rst_pipe_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n = rst_pipe_q[1];

  // front end
  logic [FREQ_W-1:0] prep_ref;
  logic [TGT_W-1:0]  prep_tgt;
  logic              prep_rd2, prep_pd2, prep_bad;

  pll_calc_prep #(.FREQ_W(FREQ_W), .TGT_W(TGT_W)) u_prep (
    .ref_hz_i   (ref_hz_i),
    .out_hz_i   (out_hz_i),
    .ref_eff_o  (prep_ref),
    .target_o   (prep_tgt),
    .ref_div2_o (prep_rd2),
    .post_div2_o(prep_pd2),
    .bad_o      (prep_bad)
  );

  // state
  calc_state_e       st_q, st_d;
  logic [FREQ_W-1:0] ref_q, ref_d;
  logic [TGT_W-1:0]  tgt_q, tgt_d;
  logic [FREQ_W-1:0] nw_q, nw_d;
  logic [FREQ_W-1:0] kq_q, kq_d;
  logic [FREQ_W-1:0] n_q, n_d;
  logic [K_W-1:0]    k_q, k_d;
  logic busy_q, busy_d, done_q, done_d, err_q, err_d;
  logic rd2_q, rd2_d, pd2_q, pd2_d, fe_q, fe_d;

  // shared divider
  logic             div_load, div_busy;
  logic [DVD_W-1:0] div_dvd, div_quot;
  logic [DVS_W-1:0] div_dvs, div_rem;
  logic             round_up;
  logic [K_W-1:0]   k_next;

  always_comb begin
    div_load = 1'b0;
    div_dvd  = '0;
    div_dvs  = '0;
    unique case (st_q)
      ST_LD_N: begin
        div_load = 1'b1;
        div_dvd  = DVD_W'(tgt_q);
        div_dvs  = ref_q;
      end
      ST_LD_K: begin
        div_load = 1'b1;
        div_dvd  = (DVD_W'(div_rem) * DVD_W'(FRAC_DECIMAL)) << K_W;
        div_dvs  = ref_q;
      end
      ST_LD_R: begin
        div_load = 1'b1;
        div_dvd  = DVD_W'(kq_q);
        div_dvs  = DVS_W'(FRAC_DECIMAL);
      end
      default: ;
    endcase
  end

  pll_calc_div #(.DVD_W(DVD_W), .DVS_W(DVS_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .load_i    (div_load),
    .dividend_i(div_dvd),
    .divisor_i (div_dvs),
    .busy_o    (div_busy),
    .quot_o    (div_quot),
    .rem_o     (div_rem)
  );

  assign round_up = {div_rem, 1'b0} >= (DVS_W + 1)'(FRAC_DECIMAL);
  assign k_next   = div_quot[K_W-1:0] + {{(K_W-1){1'b0}}, round_up};

  // next state
  always_comb begin
    st_d   = st_q;
    ref_d  = ref_q;
    tgt_d  = tgt_q;
    nw_d   = nw_q;
    kq_d   = kq_q;
    n_d    = n_q;
    k_d    = k_q;
    busy_d = busy_q;
    done_d = done_q;
    err_d  = err_q;
    rd2_d  = rd2_q;
    pd2_d  = pd2_q;
    fe_d   = fe_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          ref_d = prep_ref;
          tgt_d = prep_tgt;
          rd2_d = prep_rd2;
          pd2_d = prep_pd2;
          if (prep_bad) begin
            done_d = 1'b1;
            err_d  = 1'b1;
            n_d    = '0;
            k_d    = '0;
            fe_d   = 1'b0;
          end else begin
            busy_d = 1'b1;
            done_d = 1'b0;
            err_d  = 1'b0;
            st_d   = ST_LD_N;
          end
        end
      end
      ST_LD_N: st_d = ST_RUN_N;
      ST_RUN_N: begin
        if (!div_busy) begin
          nw_d = div_quot[FREQ_W-1:0];
          st_d = ST_LD_K;
        end
      end
      ST_LD_K: st_d = ST_RUN_K;
      ST_RUN_K: begin
        if (!div_busy) begin
          kq_d = div_quot[FREQ_W-1:0];
          st_d = ST_LD_R;
        end
      end
      ST_LD_R: st_d = ST_RUN_R;
      ST_RUN_R: begin
        if (!div_busy) begin
          n_d    = nw_q;
          k_d    = k_next;
          fe_d   = k_next != '0;
          busy_d = 1'b0;
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ref_q  <= '0;
      tgt_q  <= '0;
      nw_q   <= '0;
      kq_q   <= '0;
      n_q    <= '0;
      k_q    <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      rd2_q  <= 1'b0;
      pd2_q  <= 1'b0;
      fe_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      ref_q  <= ref_d;
      tgt_q  <= tgt_d;
      nw_q   <= nw_d;
      kq_q   <= kq_d;
      n_q    <= n_d;
      k_q    <= k_d;
      busy_q <= busy_d;
      done_q <= done_d;
      err_q  <= err_d;
      rd2_q  <= rd2_d;
      pd2_q  <= pd2_d;
      fe_q   <= fe_d;
    end
  end

  pll_calc_pack #(.K_W(K_W), .WORD_W(WORD_W), .N_BITS(N_BITS)) u_pack (
    .n_low_i   (n_q[N_BITS-1:0]),
    .k_i       (k_q),
    .word_hi_o (ctl_hi_o),
    .word_mid_o(ctl_mid_o),
    .word_lo_o (ctl_lo_o)
  );

  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign range_err_o = err_q;
  assign ref_div2_o  = rd2_q;
  assign post_div2_o = pd2_q;
  assign frac_en_o   = fe_q;
  assign n_int_o     = n_q;
  assign k_frac_o    = k_q;

  assert_busy_done_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(busy_q && done_q));
  assert_busy_ends_in_done_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    busy_q |=> (busy_q || done_q));
  assert_err_clears_result_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    err_q |-> (n_q == '0 && k_q == '0 && !fe_q && !busy_q));
  assert_frac_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (done_q && !err_q) |-> (fe_q == (k_q != '0)));
  assert_quot_fits_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (st_q == ST_RUN_N && !div_busy) |-> (div_quot[DVD_W-1:FREQ_W] == '0));
  assert_start_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
    (busy_q && start_i) |=> ($stable(rd2_q) && $stable(pd2_q) && $stable(ref_q)));
  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_n)
    (done_q && !start_i) |=> ($stable(n_q) && $stable(k_q) && $stable(err_q)));
endmodule

// File: tb/pll_factor_calc_test.sv
module pll_factor_calc_test;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 198;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] ref_hz = '0;
  logic [31:0] out_hz = '0;
  logic        busy, done, rerr, rd2, pd2, fe;
  logic [31:0] n_int;
  logic [21:0] k_frac;
  logic [8:0]  w_hi, w_mid, w_lo;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_factor_calc uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .ref_hz_i(ref_hz), .out_hz_i(out_hz),
    .busy_o(busy), .done_o(done), .range_err_o(rerr),
    .ref_div2_o(rd2), .post_div2_o(pd2), .frac_en_o(fe),
    .n_int_o(n_int), .k_frac_o(k_frac),
    .ctl_hi_o(w_hi), .ctl_mid_o(w_mid), .ctl_lo_o(w_lo)
  );

  task automatic chk(input bit ok, input string tag, input longint unsigned act,
                     input longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit              m_busy = 0, m_done = 0, m_err = 0, m_rd2 = 0, m_pd2 = 0, m_fe = 0;
  longint unsigned m_n = 0, m_k = 0, p_n = 0, p_k = 0;
  int              m_cnt = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_err = 0; m_rd2 = 0; m_pd2 = 0; m_fe = 0;
      m_n = 0; m_k = 0; m_cnt = 0;
    end else if (m_busy) begin
      m_cnt--;
      if (m_cnt == 0) begin
        m_busy = 0; m_done = 1;
        m_n = p_n; m_k = p_k; m_fe = (p_k != 0);
      end
    end else if (start) begin
      longint unsigned r, t, rm, q;
      bit bad;
      m_rd2 = ref_hz > 15000000;
      r = m_rd2 ? ref_hz / 2 : ref_hz;
      t = longint'(out_hz) * 4;
      m_pd2 = t < 90000000;
      if (m_pd2) t = t * 2;
      bad = (ref_hz == 0) || (t < 90000000) || (t > 100000000);
      if (bad) begin
        m_done = 1; m_err = 1; m_n = 0; m_k = 0; m_fe = 0;
      end else begin
        p_n = t / r;
        rm  = t % r;
        q   = (rm * 41943040) / r;
        if (q % 10 >= 5) q = q + 5;
        p_k = (q / 10) & 64'h3FFFFF;
        m_busy = 1; m_done = 0; m_err = 0; m_cnt = LAT;
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    chk(busy == m_busy, "R9 busy", busy, m_busy);
    chk(done == m_done, "R9 done", done, m_done);
    chk(rerr == m_err, "R2 range_err", rerr, m_err);
    chk(rd2 == m_rd2, "R3 ref_div2", rd2, m_rd2);
    chk(pd2 == m_pd2, "R1 post_div2", pd2, m_pd2);
    chk(n_int == m_n, "R4 n", n_int, m_n);
    chk(k_frac == m_k, "R5 k", k_frac, m_k);
    chk(fe == m_fe, "R6 frac_en", fe, m_fe);
    chk(w_hi == (((m_n & 31) << 4) | (m_k >> 18)), "R7 word hi", w_hi,
        ((m_n & 31) << 4) | (m_k >> 18));
    chk(w_mid == ((m_k >> 9) & 511), "R7 word mid", w_mid, (m_k >> 9) & 511);
    chk(w_lo == (m_k & 511), "R7 word lo", w_lo, m_k & 511);
  end

  int busy_cycles;

  task automatic run(input logic [31:0] r, input logic [31:0] o);
    @(negedge clk);
    ref_hz = r; out_hz = o; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    busy_cycles = 0;
    for (int i = 0; i < 400 && !done; i++) begin
      if (busy) busy_cycles++;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && n_int == 0 && k_frac == 0 && w_hi == 0,
        "R12 reset state", {busy, done, n_int}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(done == 0 && rerr == 0 && fe == 0, "R12 after release", {done, rerr, fe}, 0);

    run(32'd12000000, 32'd11289600);
    chk(n_int == 7, "R4 n fractional case", n_int, 7);
    chk(k_frac == 2207882, "R5 rounded k", k_frac, 2207882);
    chk(pd2 == 1, "R1 doubled", pd2, 1);
    chk(busy_cycles == LAT, "R9 busy length", busy_cycles, LAT);

    run(32'd12288000, 32'd12288000);
    chk(n_int == 8 && k_frac == 0 && fe == 0, "R6 exact ratio", k_frac, 0);

    run(32'd27000000, 32'd12288000);
    chk(rd2 == 1, "R3 halved ref", rd2, 1);
    run(32'd15000000, 32'd24576000);
    chk(rd2 == 0 && pd2 == 0, "R3 limit not halved", rd2, 0);
    run(32'd15000001, 32'd24000000);
    run(32'd18432000, 32'd22500000);
    chk(rerr == 0 && n_int == 9, "R2 lower limit legal", rerr, 0);
    run(32'd1, 32'd25000000);
    chk(rerr == 0 && n_int == 100000000, "R2 upper limit legal", n_int, 100000000);
    run(32'd12000000, 32'd25000001);
    chk(rerr == 1 && done == 1, "R2 above window", rerr, 1);
    run(32'd12000000, 32'd22400000);
    chk(rerr == 1, "R2 doubled overshoot", rerr, 1);
    run(32'd0, 32'd24576000);
    chk(rerr == 1 && done == 1 && busy_cycles == 0, "R8 zero reference", rerr, 1);
    run(32'd11289600, 32'd0);
    chk(rerr == 1 && n_int == 0, "R2 zero output", rerr, 1);
    run(32'd13000000, 32'd24000000);
    chk(w_mid == ((k_frac >> 9) & 511), "R7 packing", w_mid, (k_frac >> 9) & 511);

    // start during a running job
    @(negedge clk);
    ref_hz = 32'd12288000; out_hz = 32'd12288000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (50) @(negedge clk);
    ref_hz = 32'd0; out_hz = 32'd30000000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 400 && !done; i++) @(negedge clk);
    @(negedge clk);
    chk(rerr == 0 && n_int == 8, "R10 start ignored", n_int, 8);

    // inputs wander without start
    ref_hz = 32'd17000000; out_hz = 32'd1;
    repeat (20) @(negedge clk);
    chk(n_int == 8 && done == 1 && rd2 == 0, "R11 outputs held", n_int, 8);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule